// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit IEEE 754 binary32 operands and returns the rounded product together with four exception flags. The sign of the product is the XOR of the operand signs. The biased exponents are added and one bias of 127 is removed. The two 24-bit significands, each with its hidden leading one restored, are multiplied by a sequential shift-add engine at one partial product per cycle. The 48-bit product is then normalized and rounded in one of four modes, using a guard bit, a round bit and a sticky bit.

A request is a one-cycle `in_valid` pulse that carries both operands and the rounding mode. The control is a four-state machine:
- `S_IDLE` waits for a request. On `in_valid` it takes the transition *accept* to `S_MULT`.
- `S_MULT` adds one partial product per cycle. After the last significand bit it takes *product_done* to `S_NORM`.
- `S_NORM` normalizes, rounds, applies the special-value rules and registers the result. It then takes *pack* to `S_DONE`.
- `S_DONE` raises `out_valid` for one cycle and takes *release* back to `S_IDLE`.

Subnormal operands are treated as zero. Results too small to be normal are flushed to zero.

Top module: `fpm_mul`

## Requirements
- R1: Every result that is not NaN carries a sign equal to the XOR of the two operand sign bits (bit 31).
- R2: For normal operands whose product stays in range, with rounding mode 0 (nearest, ties to even), the result exponent field is `ea + eb - 127`. It is incremented when the 48-bit significand product is 2.0 or more, and incremented again when rounding carries out. The fraction field is the normalized product rounded to 23 bits.
- R3: The rounding mode `in_rmode` is encoded as follows: 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. Flag bit 0 (inexact) is set whenever any guard, round or sticky bit of a finite result is nonzero.
- R4: If either operand is a NaN (exponent field 255, fraction nonzero), the result is `0x7FC00000` and all flags are 0.
- R5: If one operand is zero (exponent field 0) and the other is an infinity (exponent field 255, fraction zero), the result is `0x7FC00000` and only flag bit 3 (invalid) is set.
- R6: An infinity times any non-zero, non-NaN operand gives a signed infinity, and all flags are 0.
- R7: An operand with exponent field 0, times any finite operand, gives a signed zero, and all flags are 0.
- R8: If the biased exponent after rounding is 255 or more, the result is a signed infinity with flag bits 2 (overflow) and 0 (inexact) set.
- R9: If the biased exponent after rounding is 0 or less, the result is a signed zero with flag bits 1 (underflow) and 0 (inexact) set.
- R10: `out_valid` is a one-cycle pulse. It rises on the 26th clock edge counted from the edge that accepts the request. `out_result` and `out_flags` keep their value between pulses.
- R11: An `in_valid` that arrives while a request is in flight is ignored. It neither changes the pending result nor produces an extra pulse.
- R12: After reset, `out_valid`, `out_result` and `out_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe, taken only in `S_IDLE` |
| in_a | input | 32 | First operand, binary32 |
| in_b | input | 32 | Second operand, binary32 |
| in_rmode | input | 2 | Rounding mode (0 nearest-even, 1 zero, 2 +inf, 3 -inf) |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_result | output | 32 | Rounded product, binary32 |
| out_flags | output | 4 | {invalid, overflow, underflow, inexact} |

## Verification
If the shift-add counter or the partial-product registers get out of step, the product significand is wrong. That shows up in `out_result` on the very next `out_valid`. Because rounding amplifies any low-order error into the inexact flag and the last fraction bit, randomly chosen operands expose it within a few requests.

A state machine that lingers or skips a state moves the pulse away from its fixed 26-edge position. A machine that re-accepts while busy emits an extra pulse or a result for the wrong operands. Both appear at the ports within one request time.

Errors in the special-case decode affect only the class that triggers them. For that reason, directed zero, infinity, NaN, overflow and underflow operands are mixed into the random stream.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MULT = 2'd1,
        S_NORM = 2'd2,
        S_DONE = 2'd3
    } fpm_state_t;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_ZERO      = 2'd1,
        RM_POS       = 2'd2,
        RM_NEG       = 2'd3
    } fpm_rmode_t;

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } fpm_flags_t;

endpackage

// File: rtl/fpm_classify.sv
`timescale 1ns/1ps
module fpm_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    output logic                  sign,
    output logic [EXP_W-1:0]      expo,
    output logic [FRAC_W-1:0]     frac,
    output logic                  is_zero,
    output logic                  is_inf,
    output logic                  is_nan
);
    localparam logic [EXP_W-1:0] EXP_ALL1 = '1;

    logic exp_max;
    logic frac_nz;

    always_comb begin
        sign    = word[EXP_W+FRAC_W];
        expo    = word[EXP_W+FRAC_W-1:FRAC_W];
        frac    = word[FRAC_W-1:0];
        exp_max = (expo == EXP_ALL1);
        frac_nz = |frac;
        // a zero exponent field is flushed to zero, subnormals included
        is_zero = (expo == '0);
        is_inf  = exp_max && !frac_nz;
        is_nan  = exp_max && frac_nz;
    end
endmodule

// File: rtl/fpm_shift_add.sv
`timescale 1ns/1ps
module fpm_shift_add #(
    parameter int SIG_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  logic [SIG_W-1:0]     mcand,
    input  logic [SIG_W-1:0]     mplier,
    output logic [2*SIG_W-1:0]   product
);
    localparam int PROD_W = 2 * SIG_W;

    logic [PROD_W-1:0] cand_q;
    logic [SIG_W-1:0]  plier_q;
    logic [PROD_W-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q  <= '0;
            plier_q <= '0;
            acc_q   <= '0;
        end else if (load) begin
            cand_q  <= {{SIG_W{1'b0}}, mcand};
            plier_q <= mplier;
            acc_q   <= '0;
        end else if (step) begin
            if (plier_q[0]) begin
                acc_q <= acc_q + cand_q;
            end
            cand_q  <= cand_q << 1;
            plier_q <= plier_q >> 1;
        end
    end

    assign product = acc_q;
endmodule

// File: rtl/fpm_round.sv
`timescale 1ns/1ps
module fpm_round
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                       res_sign,
    input  logic [EXP_W-1:0]           exp_a,
    input  logic [EXP_W-1:0]           exp_b,
    input  logic [1:0]                 zero_in,
    input  logic [1:0]                 inf_in,
    input  logic [1:0]                 nan_in,
    input  logic [2*(FRAC_W+1)-1:0]    prod,
    input  logic [1:0]                 rmode,
    output logic [EXP_W+FRAC_W:0]      result,
    output logic [3:0]                 flags
);
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int EXT_W  = EXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX   = (1 << EXP_W) - 1;
    localparam logic signed [EXT_W-1:0] BIAS_X = EXT_W'(BIAS);
    localparam logic signed [EXT_W-1:0] EMAX_X = EXT_W'(EMAX);
    localparam logic [EXP_W+FRAC_W:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic signed [EXT_W-1:0] e_pre, e_norm, e_fin;
    logic                    hi;
    logic [SIG_W-1:0]        mant;
    logic                    g_bit, r_bit, s_bit, inexact, inc;
    logic [SIG_W:0]          m_rnd;
    logic                    carry;
    logic [FRAC_W-1:0]       frac_out;
    fpm_flags_t              fl;

    always_comb begin
        e_pre = $signed({2'b00, exp_a}) + $signed({2'b00, exp_b}) - BIAS_X;
        hi    = prod[PROD_W-1];
        if (hi) begin
            mant  = prod[PROD_W-1 -: SIG_W];
            g_bit = prod[PROD_W-1-SIG_W];
            r_bit = prod[PROD_W-2-SIG_W];
            s_bit = |prod[PROD_W-3-SIG_W:0];
        end else begin
            mant  = prod[PROD_W-2 -: SIG_W];
            g_bit = prod[PROD_W-2-SIG_W];
            r_bit = prod[PROD_W-3-SIG_W];
            s_bit = |prod[PROD_W-4-SIG_W:0];
        end
        e_norm  = e_pre + (hi ? EXT_W'(1) : EXT_W'(0));
        inexact = g_bit | r_bit | s_bit;

        unique case (fpm_rmode_t'(rmode))
            RM_NEAR_EVEN: inc = g_bit & (r_bit | s_bit | mant[0]);
            RM_ZERO:      inc = 1'b0;
            RM_POS:       inc = inexact & ~res_sign;
            RM_NEG:       inc = inexact & res_sign;
        endcase

        m_rnd    = {1'b0, mant} + {{SIG_W{1'b0}}, inc};
        carry    = m_rnd[SIG_W];
        frac_out = carry ? m_rnd[SIG_W-1:1] : m_rnd[FRAC_W-1:0];
        e_fin    = e_norm + (carry ? EXT_W'(1) : EXT_W'(0));
    end

    always_comb begin
        fl = '0;
        if (|nan_in) begin
            result = QNAN;
        end else if ((zero_in[0] & inf_in[1]) | (inf_in[0] & zero_in[1])) begin
            result     = QNAN;
            fl.invalid = 1'b1;
        end else if (|inf_in) begin
            result = {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (|zero_in) begin
            result = {res_sign, {(EXP_W+FRAC_W){1'b0}}};
        end else if (e_fin >= EMAX_X) begin
            result      = {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            fl.overflow = 1'b1;
            fl.inexact  = 1'b1;
        end else if (e_fin <= $signed(EXT_W'(0))) begin
            result       = {res_sign, {(EXP_W+FRAC_W){1'b0}}};
            fl.underflow = 1'b1;
            fl.inexact   = 1'b1;
        end else begin
            result     = {res_sign, e_fin[EXP_W-1:0], frac_out};
            fl.inexact = inexact;
        end
        flags = fl;
    end
endmodule

// File: rtl/fpm_mul.sv
`timescale 1ns/1ps
module fpm_mul
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [EXP_W+FRAC_W:0] in_a,
    input  logic [EXP_W+FRAC_W:0] in_b,
    input  logic [1:0]            in_rmode,
    output logic                  out_valid,
    output logic [EXP_W+FRAC_W:0] out_result,
    output logic [3:0]            out_flags
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int CNT_W  = $clog2(SIG_W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(SIG_W - 1);
    localparam logic [WORD_W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    fpm_state_t        state_q, state_d;
    logic [WORD_W-1:0] op_q [2];
    logic [1:0]        rm_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              load, step, pack;

    logic              sgn_w  [2];
    logic [EXP_W-1:0]  exp_w  [2];
    logic [FRAC_W-1:0] frac_w [2];
    logic [1:0]        zero_w, inf_w, nan_w;

    logic [PROD_W-1:0] prod;
    logic [WORD_W-1:0] rnd_result;
    logic [3:0]        rnd_flags;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (in_valid) state_d = S_MULT;            // accept
            S_MULT: if (cnt_q == LAST_STEP) state_d = S_NORM;  // product_done
            S_NORM: state_d = S_DONE;                          // pack
            S_DONE: state_d = S_IDLE;                          // release
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // state-decoded controls
    always_comb begin
        load      = (state_q == S_IDLE) && in_valid;
        step      = (state_q == S_MULT);
        pack      = (state_q == S_NORM);
        out_valid = (state_q == S_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q[0] <= '0;
            op_q[1] <= '0;
            rm_q    <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            op_q[0] <= in_a;
            op_q[1] <= in_b;
            rm_q    <= in_rmode;
            cnt_q   <= '0;
        end else if (step) begin
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fpm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .word    (op_q[gi]),
            .sign    (sgn_w[gi]),
            .expo    (exp_w[gi]),
            .frac    (frac_w[gi]),
            .is_zero (zero_w[gi]),
            .is_inf  (inf_w[gi]),
            .is_nan  (nan_w[gi])
        );
    end

    fpm_shift_add #(.SIG_W(SIG_W)) u_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .mcand   ({1'b1, (load ? in_a[FRAC_W-1:0] : frac_w[0])}),
        .mplier  ({1'b1, (load ? in_b[FRAC_W-1:0] : frac_w[1])}),
        .product (prod)
    );

    fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .res_sign (sgn_w[0] ^ sgn_w[1]),
        .exp_a    (exp_w[0]),
        .exp_b    (exp_w[1]),
        .zero_in  (zero_w),
        .inf_in   (inf_w),
        .nan_in   (nan_w),
        .prod     (prod),
        .rmode    (rm_q),
        .result   (rnd_result),
        .flags    (rnd_flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result <= '0;
            out_flags  <= '0;
        end else if (pack) begin
            out_result <= rnd_result;
            out_flags  <= rnd_flags;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MULT) |=> ($stable(out_result) && $stable(out_flags))); // R10
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> ($stable(op_q[0]) && $stable(op_q[1]) && $stable(rm_q))); // R11
    AST_INVALID_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[3]) |-> (out_result == QNAN)); // R5
    AST_NO_OVF_UNF: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_flags[2] && out_flags[1])); // R8
    AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[2]) |-> (out_result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}})); // R8
    AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[1]) |-> (out_result[WORD_W-2:0] == '0)); // R9
endmodule

// File: tb/tb_fpm_mul.sv
`timescale 1ns/1ps
module tb_fpm_mul;
    localparam logic [31:0] QNAN = 32'h7FC00000;
    localparam int LAT = 26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0, in_b = '0;
    logic [1:0]  in_rmode = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic [3:0]  out_flags;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    fpm_mul dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_rmode(in_rmode), .out_valid(out_valid), .out_result(out_result),
        .out_flags(out_flags)
    );

    function automatic logic [35:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                            input logic [1:0] rm);
        logic s, za, zb, ia, ib, na, nb, g, r, st, inx, inc;
        logic [47:0] p;
        logic [23:0] m;
        logic [24:0] m25;
        logic [22:0] fr;
        int e;
        s  = a[31] ^ b[31];
        za = (a[30:23] == 0);
        zb = (b[30:23] == 0);
        ia = (a[30:23] == 8'hFF) && (a[22:0] == 0);
        ib = (b[30:23] == 8'hFF) && (b[22:0] == 0);
        na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        if (na || nb) return {4'b0000, QNAN};
        if ((za && ib) || (ia && zb)) return {4'b1000, QNAN};
        if (ia || ib) return {4'b0000, s, 8'hFF, 23'd0};
        if (za || zb) return {4'b0000, s, 31'd0};
        p = {24'd0, 1'b1, a[22:0]} * {24'd0, 1'b1, b[22:0]};
        e = int'(a[30:23]) + int'(b[30:23]) - 127;
        if (p[47]) begin
            m = p[47:24]; g = p[23]; r = p[22]; st = |p[21:0]; e = e + 1;
        end else begin
            m = p[46:23]; g = p[22]; r = p[21]; st = |p[20:0];
        end
        inx = g | r | st;
        case (rm)
            2'd0: inc = g & (r | st | m[0]);
            2'd1: inc = 1'b0;
            2'd2: inc = inx & ~s;
            default: inc = inx & s;
        endcase
        m25 = {1'b0, m} + 25'(inc);
        if (m25[24]) begin e = e + 1; fr = 23'd0; end
        else fr = m25[22:0];
        if (e >= 255) return {4'b0101, s, 8'hFF, 23'd0};
        if (e <= 0) return {4'b0011, s, 31'd0};
        return {3'b000, inx, s, e[7:0], fr};
    endfunction

    function automatic string tag_of(input logic [35:0] exp_v, input logic [1:0] rm,
                                     input logic [31:0] a, input logic [31:0] b);
        if ((a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0)) return "R4";
        if (exp_v[35]) return "R5";
        if (exp_v[34]) return "R8";
        if (exp_v[33]) return "R9";
        if (exp_v[30:23] == 8'hFF) return "R6";
        if (exp_v[30:0] == 0) return "R7";
        return (rm == 2'd0) ? "R2" : "R3";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [35:0] act, input logic [35:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp_v);
        end
    endtask

    // issue one request; optionally pulse in_valid again while busy
    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm,
                       input bit check_lat, input bit intrude);
        logic [35:0] exp_v;
        int n;
        exp_v = ref_mul(a, b, rm);
        @(negedge clk);
        in_a = a; in_b = b; in_rmode = rm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        n = 1;
        while (!out_valid && n < 100) begin
            if (intrude && n == 5) begin
                in_a = 32'h3F800000; in_b = 32'h40400000; in_rmode = 2'd1; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        in_valid = 1'b0;
        if (check_lat) check("R10", "latency", 36'(n), 36'(LAT));
        check(tag_of(exp_v, rm, a, b), "product", {out_flags, out_result}, exp_v);
        if (intrude) check("R11", "busy request ignored", {out_flags, out_result}, exp_v);
        if (exp_v[30:0] != QNAN[30:0] || exp_v[31])
            if (!(exp_v[30:23] == 8'hFF && exp_v[22:0] != 0))
                check("R1", "sign", 36'(out_result[31]), 36'(a[31] ^ b[31]));
        @(negedge clk);
        if (check_lat) check("R10", "single pulse", 36'(out_valid), 36'd0);
        if (intrude) begin
            for (int k = 0; k < 30; k++) begin
                if (out_valid) begin
                    check("R11", "extra pulse", 36'd1, 36'd0);
                    break;
                end
                @(negedge clk);
            end
        end
    endtask

    function automatic logic [31:0] rnd_operand();
        logic [31:0] v;
        int sel;
        sel = int'($urandom % 16);
        v[31] = 1'($urandom);
        v[22:0] = 23'($urandom);
        case (sel)
            0: v[30:23] = 8'd0;
            1: begin v[30:23] = 8'hFF; if ($urandom % 2 == 0) v[22:0] = 23'd0; end
            2: v[30:23] = 8'(200 + $urandom % 55);
            3: v[30:23] = 8'(1 + $urandom % 60);
            default: v[30:23] = 8'(60 + $urandom % 140);
        endcase
        return v;
    endfunction

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R12", "reset state", {out_flags, out_result, 3'b000, out_valid},
              {4'd0, 32'd0, 4'd0});
        rst_n = 1'b1;
        @(negedge clk);

        run(32'h40000000, 32'h40400000, 2'd0, 1'b1, 1'b0);             // R2 2*3
        check("R2", "2*3 constant", {out_flags, out_result}, {4'd0, 32'h40C00000});
        run(32'hBFC00000, 32'hBFC00000, 2'd0, 1'b1, 1'b0);             // R1 R2
        check("R2", "-1.5*-1.5 constant", {out_flags, out_result}, {4'd0, 32'h40100000});
        for (int m = 0; m < 4; m++) begin
            run(32'h3FFFFFFF, 32'h3FFFFFFF, 2'(m), 1'b0, 1'b0);        // R3 carry
            run(32'hBF800001, 32'h3F800001, 2'(m), 1'b0, 1'b0);        // R3 sign-dependent
        end
        run(32'h7FC00001, 32'h3F800000, 2'd0, 1'b0, 1'b0);             // R4
        run(32'h00000000, 32'hFF800000, 2'd0, 1'b0, 1'b0);             // R5
        check("R5", "zero*inf", {out_flags, out_result}, {4'b1000, QNAN});
        run(32'hFF800000, 32'h40000000, 2'd0, 1'b0, 1'b0);             // R6
        check("R6", "-inf*2", {out_flags, out_result}, {4'd0, 32'hFF800000});
        run(32'h80000000, 32'h42000000, 2'd0, 1'b0, 1'b0);             // R7
        run(32'h00400000, 32'hC2000000, 2'd0, 1'b0, 1'b0);             // R7 subnormal
        run(32'h7F000000, 32'hFF000000, 2'd0, 1'b0, 1'b0);             // R8
        check("R8", "overflow", {out_flags, out_result}, {4'b0101, 32'hFF800000});
        run(32'h00800000, 32'h00800000, 2'd0, 1'b0, 1'b0);             // R9
        check("R9", "underflow", {out_flags, out_result}, {4'b0011, 32'h00000000});
        run(32'h3FC00000, 32'h40200000, 2'd0, 1'b1, 1'b1);             // R11

        for (int i = 0; i < 300; i++) begin
            run(rnd_operand(), rnd_operand(), 2'($urandom), (i % 50) == 0, (i % 60) == 7);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule